// File: doc/BRIEF.md
# Latched-Input Parallel-to-Serial Shift Register

This block turns an 8-bit parallel word into a serial bit stream. It has two registers. A holding register takes the parallel bus on a rising edge of its capture strobe. A shift chain either takes a copy of the holding register, when the level-sensitive load control is low, or moves one place toward its output on each rising edge of the shift strobe. On a shift, the serial input enters the first stage. The last stage drives a serial output. That output has an active-low enable, so several units can share one serial line.

Everything runs on one system clock. The two strobes arrive as already synchronised levels, and the block finds their rising edges itself. The output driver appears as a data value plus a drive flag. The integrator builds the actual three-state buffer from those two signals.

Top module: `latched_piso`

## Requirements
- R1: An active-low synchronous reset clears the holding register and the shift chain to zero.
- R2: A low-to-high change on `cap_stb` makes the holding register take `par_in` at that clock edge.
- R3: While `load_n` is low and `cap_stb` does not rise, the shift chain copies the holding register on every clock edge. Shift strobe edges are ignored while this happens.
- R4: While `load_n` is low, a rise of `cap_stb` loads the shift chain with the current `par_in` value, so new data passes straight through in the same clock edge.
- R5: While `load_n` is high, each low-to-high change of `shf_stb` moves stage i into stage i+1 and puts `ser_in` into stage 0. A strobe held high causes exactly one shift, and with no rise the chain holds its value.
- R6: When both strobes rise in the same cycle with `load_n` high, the chain shifts and the holding register captures `par_in`. Neither operation changes the result of the other.
- R7: `sout_drive` equals the inverse of `oe_n` in the same cycle, and whenever it is 1, `sout_val` equals stage 7.
- R8: `oe_n` changes neither register. Shifts made while the output is disabled still take effect.
- R9: After a parallel load, eight shifts present the loaded bits on `sout_val` in the order bit 7, 6, … 0.
- R10: Without a rise of `cap_stb`, the holding register keeps its value, whatever happens on the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_in | input | 8 | Parallel data bus |
| cap_stb | input | 1 | Capture strobe for the holding register (rising edge acts) |
| shf_stb | input | 1 | Shift strobe (rising edge acts) |
| load_n | input | 1 | Low: load the chain from the holding register; high: allow shifting |
| ser_in | input | 1 | Serial data into stage 0 |
| oe_n | input | 1 | Active-low output enable |
| sout_val | output | 1 | Serial output data (stage 7) |
| sout_drive | output | 1 | 1 when the serial output is driven, 0 when high-impedance |

## Verification
The bench targets the cycle in which a capture and a load coincide. A design that loaded the old holding value there would emit stale data one word late. It raises both strobes together with loading off, which exposes a design where the capture corrupts the shift or the shift suppresses the capture. It holds the shift strobe high for several cycles to catch level-triggered shifting, which would drain the whole word at once. It also shifts with the output disabled, catching a design that ties register activity to the enable. Finally, it shifts a known word out completely to confirm the bit order, and a reversed chain would emit the word backwards.

// File: rtl/piso_pkg.sv
package piso_pkg;

  // What the shift chain does on a given clock edge
  typedef enum logic [1:0] {
    ACT_HOLD       = 2'd0,
    ACT_SHIFT      = 2'd1,
    ACT_LOAD_STORE = 2'd2,
    ACT_LOAD_PINS  = 2'd3
  } sr_act_e;

  // Load control overrides shifting; a capture during load passes pins through
  function automatic sr_act_e decode_act(input logic load_n,
                                         input logic cap_rise,
                                         input logic shf_rise);
    if (!load_n) begin
      return cap_rise ? ACT_LOAD_PINS : ACT_LOAD_STORE;
    end
    return shf_rise ? ACT_SHIFT : ACT_HOLD;
  endfunction

endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // A held level produces a single-cycle event only
  p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/storage_reg.sv
module storage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_rise,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] store_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        store_q <= '0;
    else if (cap_rise) store_q <= par_in;
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> store_q == $past(par_in));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_rise |=> $stable(store_q));

endmodule

// File: rtl/shift_chain.sv
module shift_chain
  import piso_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sr_act_e      act,
  input  logic         ser_in,
  input  logic [W-1:0] store_q,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] shift_q
);
  logic [W-1:0] shift_d;

  // Stage 0 takes the serial bit, every other stage takes its predecessor
  function automatic logic [W-1:0] step_toward_out(input logic [W-1:0] cur,
                                                   input logic         bit_in);
    logic [W-1:0] nxt;
    nxt[0] = bit_in;
    for (int i = 1; i < W; i++) nxt[i] = cur[i-1];
    return nxt;
  endfunction

  always_comb begin
    unique case (act)
      ACT_SHIFT:      shift_d = step_toward_out(shift_q, ser_in);
      ACT_LOAD_STORE: shift_d = store_q;
      ACT_LOAD_PINS:  shift_d = par_in;
      default:        shift_d = shift_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

endmodule

// File: rtl/latched_piso.sv
module latched_piso
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             cap_stb,
  input  logic             shf_stb,
  input  logic             load_n,
  input  logic             ser_in,
  input  logic             oe_n,
  output logic             sout_val,
  output logic             sout_drive
);
  localparam int NSTB = 2;
  localparam int MSB  = WIDTH - 1;

  logic [NSTB-1:0]  stb_lvl;
  logic [NSTB-1:0]  stb_rise;
  logic             cap_rise;
  logic             shf_rise;
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] shift_q;
  sr_act_e          act;

  assign stb_lvl = {shf_stb, cap_stb};

  for (genvar g = 0; g < NSTB; g++) begin : g_edge
    strobe_rise u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (stb_lvl[g]),
      .rise  (stb_rise[g])
    );
  end

  assign cap_rise = stb_rise[0];
  assign shf_rise = stb_rise[1];

  assign act = decode_act(load_n, cap_rise, shf_rise);

  storage_reg #(.W(WIDTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_rise (cap_rise),
    .par_in   (par_in),
    .store_q  (store_q)
  );

  shift_chain #(.W(WIDTH)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .ser_in  (ser_in),
    .store_q (store_q),
    .par_in  (par_in),
    .shift_q (shift_q)
  );

  assign sout_val   = shift_q[MSB];
  assign sout_drive = ~oe_n;

  // Guards on the shift chain, written from the raw control inputs
  p_load_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !cap_rise) |=> shift_q == $past(store_q));

  p_pass_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && cap_rise) |=> shift_q == $past(par_in));

  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && shf_rise) |=> shift_q == {$past(shift_q[MSB-1:0]), $past(ser_in)});

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !shf_rise) |=> $stable(shift_q));

  p_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && shf_rise && cap_rise) |=> store_q == $past(par_in));

endmodule

// File: tb/test_latched_piso.sv
module test_latched_piso;
  localparam int CLK_T = 10;
  localparam int W = 8;
  localparam int NV = 18;

  // {cap, shf, load_n, ser, oe_n, par}
  localparam logic [12:0] TBL [NV] = '{
    {5'b00100, 8'hA5},
    {5'b10100, 8'hA5},
    {5'b00000, 8'h00},
    {5'b00100, 8'h00},
    {5'b01110, 8'h00},
    {5'b00100, 8'h00},
    {5'b01100, 8'h00},
    {5'b00101, 8'h00},
    {5'b01111, 8'h00},
    {5'b00100, 8'h00},
    {5'b10000, 8'h3C},
    {5'b00000, 8'h00},
    {5'b11110, 8'hC3},
    {5'b00100, 8'h00},
    {5'b00000, 8'h00},
    {5'b01010, 8'h00},
    {5'b00100, 8'h00},
    {5'b00110, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] par_in;
  logic cap_stb, shf_stb, load_n, ser_in, oe_n;
  logic sout_val, sout_drive;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench reference state
  logic [W-1:0] m_store, m_shift;
  logic m_pc, m_ps;

  always #(CLK_T/2) clk = ~clk;

  latched_piso #(.WIDTH(W)) i_latched_piso (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .cap_stb(cap_stb),
    .shf_stb(shf_stb), .load_n(load_n), .ser_in(ser_in), .oe_n(oe_n),
    .sout_val(sout_val), .sout_drive(sout_drive)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // apply one cycle of inputs, update reference, compare outputs
  task automatic step(input logic [12:0] v, input string tag);
    logic cr, sr;
    {cap_stb, shf_stb, load_n, ser_in, oe_n, par_in} = v;
    @(posedge clk);
    @(negedge clk);
    cr = cap_stb && !m_pc;
    sr = shf_stb && !m_ps;
    if (!load_n) m_shift = cr ? par_in : m_store;
    else if (sr) m_shift = {m_shift[W-2:0], ser_in};
    if (cr) m_store = par_in;
    m_pc = cap_stb;
    m_ps = shf_stb;
    check({tag, " drive (R7)"}, sout_drive, !oe_n);
    if (sout_drive) check({tag, " data"}, sout_val, m_shift[W-1]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {cap_stb, shf_stb, load_n, ser_in, oe_n, par_in} = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_store = '0; m_shift = '0; m_pc = 1'b0; m_ps = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1: reset state visible at output; loading after reset shows zero store
    check("R1 reset out", sout_val, 1'b0);
    check("R1 reset drive", sout_drive, 1'b1);
    step({5'b00000, 8'hFF}, "R1 load zero store");
    check("R1 store cleared", sout_val, 1'b0);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R10
    for (int k = 0; k < NV; k++) step(TBL[k], $sformatf("vec%0d R2-R8", k));

    // R9: load 0x96 directly through the pins, then shift out in order
    step({5'b00100, 8'h00}, "R9 prep");
    step({5'b10000, 8'h96}, "R9 load R4");
    for (int i = 0; i < W; i++) begin
      check("R9 order", sout_val, 8'h96 >> (W-1-i));
      step({5'b01100, 8'h00}, "R9 shift");
      step({5'b00100, 8'h00}, "R9 low");
    end
    check("R9 drained", sout_val, 1'b0);

    // R5: held-high shift strobe shifts once only
    step({5'b10000, 8'h80}, "R5 load 80");
    step({5'b00100, 8'h00}, "R5 idle");
    step({5'b01110, 8'h00}, "R5 rise");
    check("R5 one shift", sout_val, 1'b0);
    step({5'b01100, 8'h00}, "R5 held");
    step({5'b01100, 8'h00}, "R5 held");
    check("R5 no repeat", sout_val, m_shift[W-1]);

    // R10: store untouched by par_in and shifts without capture edge
    step({5'b00100, 8'h5A}, "R10 pins move");
    step({5'b00000, 8'h00}, "R10 reload");
    check("R10 store kept 80", sout_val, 1'b1);

    // R8: toggling enable leaves contents; output back after re-enable
    step({5'b00101, 8'h00}, "R8 off");
    check("R8 hiz", sout_drive, 1'b0);
    step({5'b00100, 8'h00}, "R8 on");
    check("R8 content", sout_val, 1'b1);

    // R1: reset mid-run clears loaded data
    do_reset();
    check("R1 mid reset", sout_val, 1'b0);
    step({5'b00000, 8'h00}, "R1 store zero");
    check("R1 mid store", sout_val, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule